// File: doc/BRIEF.md
# Dual-Rail AES Encryption Round

This block applies one full AES encryption round to a 128-bit state carried on dual-rail wires, two wires per bit. A round key is XORed in after the state bytes pass through substitution, row rotation and column mixing. Every stage between the input ports and the output register works on rail pairs, so a spacer wavefront (all wires low) moves through the logic in the same way as a data wavefront. The GF(2^8) doubling inside the column mixer is one example: it shifts rail pairs and applies dual-rail XORs, which keeps the spacer state intact at every step.

A wavefront register at the output follows the usual null-convention handshake. It accepts a data wavefront only when the downstream request is high and every state and key pair carries data. It holds that wavefront until the request falls and both inputs have returned to the spacer. The completion output goes low while the output holds data and goes high while it holds the spacer. An upstream sequencer uses it to decide when to send the next wavefront. A single round is evaluated per data wavefront; iteration over rounds is left to the user.

Top module: `dr_aes_round`

## Requirements
- R1: Bit i of a 128-bit value sits on wires [2i+1:2i], with the high wire as the true rail: 00 is the spacer (NULL), 01 is DATA0, 10 is DATA1 and 11 is illegal. Byte n occupies single-rail bits [127-8n:120-8n]. Bytes fill columns first, so byte n lies in row n%4 of column n/4.
- R2: While rst_n is low, the result is all NULL and ko is 1.
- R3: A latched DATA result equals AddRoundKey(MixColumns(ShiftRows(SubBytes(state)))) computed on the single-rail values. ShiftRows rotates row r left by r bytes, and MixColumns reduces by the polynomial 0x11B.
- R4: When ki is 1 and every pair of state_dr and key_dr is DATA, the result shows DATA after the next rising clock edge.
- R5: While any input pair is NULL, a result that is NULL stays NULL and ko stays 1.
- R6: While ki is 0, a result that is NULL stays NULL even when both inputs are complete DATA.
- R7: A DATA result is held until ki is 0 and every pair of both inputs is NULL. The result returns to NULL one rising edge after that.
- R8: The result is always either all NULL or all DATA. ko is 0 exactly when all 128 pairs are DATA and 1 exactly when all are NULL.
- R9: No result pair ever shows 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the wavefront register |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_dr | input | 256 | Dual-rail input state |
| key_dr | input | 256 | Dual-rail round key |
| ki | input | 1 | Request from downstream: 1 asks for DATA, 0 asks for NULL |
| ko | output | 1 | Completion: 0 while the result is DATA, 1 while NULL |
| result_dr | output | 256 | Dual-rail round result |

## Verification
A corrupted byte path shows up at the result within one edge of the first complete wavefront, as a wrong value or as a pair stuck at NULL. A reversed row rotation or a wrong reduction constant shows up as a mismatch against the single-rail round model, and stimulus bytes with the top bit set are included so that reduction errors appear. A faulty completion or hold rule shows up as ko or the result changing while inputs are partial or ki forbids it, and the bench looks at this over several edges after each such stimulus.

// File: rtl/dr_aes_pkg.sv
package dr_aes_pkg;
   localparam int BYTE_W = 8;
   localparam int PAIR_W = 2 * BYTE_W;

   typedef logic [PAIR_W-1:0] dr_byte_t;

   // dual-rail XOR on one rail pair: NULL on either side gives NULL
   function automatic logic [1:0] dr_xor_bit(input logic [1:0] a, input logic [1:0] b);
      return {(a[1] & b[0]) | (a[0] & b[1]), (a[0] & b[0]) | (a[1] & b[1])};
   endfunction

   function automatic dr_byte_t dr_xor_byte(input dr_byte_t a, input dr_byte_t b);
      dr_byte_t z;
      for (int k = 0; k < BYTE_W; k++) z[2*k +: 2] = dr_xor_bit(a[2*k +: 2], b[2*k +: 2]);
      return z;
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] poly);
      logic [7:0] acc, sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[7] ? ({sh[6:0], 1'b0} ^ poly) : {sh[6:0], 1'b0};
      end
      return acc;
   endfunction

   // x^254 through an addition chain; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] x, input logic [7:0] poly);
      logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
      x2   = gf_mul(x, x, poly);
      x3   = gf_mul(x2, x, poly);
      x6   = gf_mul(x3, x3, poly);
      x12  = gf_mul(x6, x6, poly);
      x15  = gf_mul(x12, x3, poly);
      x30  = gf_mul(x15, x15, poly);
      x60  = gf_mul(x30, x30, poly);
      x120 = gf_mul(x60, x60, poly);
      x240 = gf_mul(x120, x120, poly);
      x252 = gf_mul(x240, x12, poly);
      return gf_mul(x252, x2, poly);
   endfunction

   function automatic logic [7:0] sbox(input logic [7:0] x, input logic [7:0] poly);
      logic [7:0] v, s;
      localparam logic [7:0] AFF_C = 8'h63;
      v = gf_inv(x, poly);
      for (int i = 0; i < 8; i++)
         s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ AFF_C[i];
      return s;
   endfunction
endpackage

// File: rtl/dr_sbox.sv
module dr_sbox
   import dr_aes_pkg::*;
#(
   parameter logic [7:0] POLY = 8'h1B
) (
   input  dr_byte_t a_dr,
   output dr_byte_t y_dr
);
   logic       done;
   logic [7:0] val, sub;

   always_comb begin
      done = 1'b1;
      for (int k = 0; k < BYTE_W; k++) begin
         done   = done & (a_dr[2*k+1] | a_dr[2*k]);
         val[k] = a_dr[2*k+1];
      end
      sub = sbox(val, POLY);
      for (int k = 0; k < BYTE_W; k++)
         y_dr[2*k +: 2] = done ? {sub[k], ~sub[k]} : 2'b00;
   end

   always_comb begin
      if (a_dr == '0) a_r1_sbox_null : assert (y_dr == '0);
   end
endmodule

// File: rtl/dr_gf_double.sv
module dr_gf_double
   import dr_aes_pkg::*;
#(
   parameter logic [7:0] POLY = 8'h1B
) (
   input  dr_byte_t a_dr,
   output dr_byte_t y_dr
);
   logic       byte_done;
   logic [1:0] msb;
   dr_byte_t   sh;

   always_comb begin
      byte_done = 1'b1;
      for (int k = 0; k < BYTE_W; k++) byte_done = byte_done & (a_dr[2*k+1] | a_dr[2*k]);
   end

   assign msb = a_dr[PAIR_W-1 -: 2];
   // shifted-in zero: DATA0 when the operand is DATA, NULL otherwise
   assign sh  = {a_dr[PAIR_W-3:0], 1'b0, byte_done};

   for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
      if (POLY[k]) begin : g_red
         assign y_dr[2*k +: 2] = dr_xor_bit(sh[2*k +: 2], msb);
      end else begin : g_pass
         assign y_dr[2*k +: 2] = sh[2*k +: 2];
      end
   end

   always_comb begin
      if (a_dr == '0) a_r1_dbl_null : assert (y_dr == '0);
   end
endmodule

// File: rtl/dr_mixcol.sv
module dr_mixcol
   import dr_aes_pkg::*;
#(
   parameter int         NROW = 4,
   parameter logic [7:0] POLY = 8'h1B
) (
   input  logic [NROW*PAIR_W-1:0] col_dr,
   output logic [NROW*PAIR_W-1:0] mix_dr
);
   dr_byte_t a_b [NROW];
   dr_byte_t d_b [NROW];
   dr_byte_t t_b [NROW];

   for (genvar r = 0; r < NROW; r++) begin : g_row
      assign a_b[r] = col_dr[PAIR_W*r +: PAIR_W];
      dr_gf_double #(.POLY(POLY)) u_dbl (.a_dr(a_b[r]), .y_dr(d_b[r]));
      assign t_b[r] = dr_xor_byte(d_b[r], a_b[r]);
      assign mix_dr[PAIR_W*r +: PAIR_W] =
         dr_xor_byte(dr_xor_byte(d_b[r], t_b[(r+1)%NROW]),
                     dr_xor_byte(a_b[(r+2)%NROW], a_b[(r+3)%NROW]));
   end

   always_comb begin
      if (col_dr == '0) a_r8_mix_null : assert (mix_dr == '0);
   end
endmodule

// File: rtl/dr_aes_round.sv
module dr_aes_round
   import dr_aes_pkg::*;
#(
   parameter int         NROW = 4,
   parameter int         NCOL = 4,
   parameter logic [7:0] POLY = 8'h1B,
   localparam int        NBYTE = NROW * NCOL,
   localparam int        NPAIR = NBYTE * BYTE_W,
   localparam int        DRW   = 2 * NPAIR
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [DRW-1:0] state_dr,
   input  logic [DRW-1:0] key_dr,
   input  logic           ki,
   output logic           ko,
   output logic [DRW-1:0] result_dr
);
   if (NROW != 4 || NCOL != 4) begin : g_bad_shape
      $error("dr_aes_round: the AES state must be 4 rows by 4 columns");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("dr_aes_round: reduction constant must have bit 0 set");
   end

   dr_byte_t st_b [NBYTE];
   dr_byte_t ky_b [NBYTE];
   dr_byte_t sb_b [NBYTE];
   dr_byte_t sr_b [NBYTE];
   dr_byte_t mc_b [NBYTE];
   logic [DRW-1:0] res_dr;
   logic [NROW*PAIR_W-1:0] col_in  [NCOL];
   logic [NROW*PAIR_W-1:0] col_out [NCOL];

   for (genvar n = 0; n < NBYTE; n++) begin : g_byte
      assign st_b[n] = state_dr[DRW-PAIR_W*(n+1) +: PAIR_W];
      assign ky_b[n] = key_dr[DRW-PAIR_W*(n+1) +: PAIR_W];
      dr_sbox #(.POLY(POLY)) u_sb (.a_dr(st_b[n]), .y_dr(sb_b[n]));
      assign res_dr[DRW-PAIR_W*(n+1) +: PAIR_W] = dr_xor_byte(mc_b[n], ky_b[n]);
   end

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      for (genvar r = 0; r < NROW; r++) begin : g_row
         localparam int SRC = NROW * ((c + r) % NCOL) + r;
         assign sr_b[NROW*c+r] = sb_b[SRC];
         assign col_in[c][PAIR_W*r +: PAIR_W] = sr_b[NROW*c+r];
         assign mc_b[NROW*c+r] = col_out[c][PAIR_W*r +: PAIR_W];
      end
      dr_mixcol #(.NROW(NROW), .POLY(POLY)) u_mix (.col_dr(col_in[c]), .mix_dr(col_out[c]));
   end

   logic st_data, ky_data, res_data, st_null, ky_null;
   always_comb begin
      st_data  = 1'b1;
      ky_data  = 1'b1;
      res_data = 1'b1;
      for (int i = 0; i < NPAIR; i++) begin
         st_data  = st_data  & (state_dr[2*i+1] | state_dr[2*i]);
         ky_data  = ky_data  & (key_dr[2*i+1]   | key_dr[2*i]);
         res_data = res_data & (res_dr[2*i+1]   | res_dr[2*i]);
      end
      st_null = (state_dr == '0);
      ky_null = (key_dr == '0);
   end

   logic           hold_q;
   logic [DRW-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         out_q  <= '0;
      end else if (!hold_q && ki && st_data && ky_data && res_data) begin
         hold_q <= 1'b1;
         out_q  <= res_dr;
      end else if (hold_q && !ki && st_null && ky_null) begin
         hold_q <= 1'b0;
         out_q  <= '0;
      end
   end

   assign ko        = ~hold_q;
   assign result_dr = out_q;

   logic out_illegal, out_all_data;
   always_comb begin
      out_illegal  = 1'b0;
      out_all_data = 1'b1;
      for (int i = 0; i < NPAIR; i++) begin
         out_illegal  = out_illegal | (result_dr[2*i+1] & result_dr[2*i]);
         out_all_data = out_all_data & (result_dr[2*i+1] | result_dr[2*i]);
      end
   end

   a_r9_no_illegal : assert property (@(posedge clk) disable iff (!rst_n) !out_illegal);
   a_r8_ko_data    : assert property (@(posedge clk) disable iff (!rst_n) !ko |-> out_all_data);
   a_r8_ko_null    : assert property (@(posedge clk) disable iff (!rst_n) ko |-> (result_dr == '0));
   a_r6_ki_gate    : assert property (@(posedge clk) disable iff (!rst_n) $fell(ko) |-> $past(ki));
   a_r5_complete   : assert property (@(posedge clk) disable iff (!rst_n)
                                      $fell(ko) |-> $past(st_data && ky_data));
   a_r7_release    : assert property (@(posedge clk) disable iff (!rst_n)
                                      $rose(ko) |-> $past(!ki && st_null && ky_null));
   a_r7_hold_val   : assert property (@(posedge clk) disable iff (!rst_n)
                                      (!ko && $past(!ko)) |-> $stable(result_dr));
endmodule

// File: tb/dr_aes_round_test.sv
module dr_aes_round_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] state_dr = '0;
   logic [255:0] key_dr = '0;
   logic         ki = 1'b0;
   logic         ko;
   logic [255:0] result_dr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dr_aes_round uut (.clk(clk), .rst_n(rst_n), .state_dr(state_dr), .key_dr(key_dr),
                     .ki(ki), .ko(ko), .result_dr(result_dr));

   localparam int NV = 5;
   localparam logic [127:0] VEC_S [NV] = '{
      128'h193de3bea0f4e22b9ac68d2ae9f84808,
      128'h00000000000000000000000000000000,
      128'hffffffffffffffffffffffffffffffff,
      128'h80818283c0c1c2c3f0e1d2c3b4a59687,
      128'h0123456789abcdeffedcba9876543210 };
   localparam logic [127:0] VEC_K [NV] = '{
      128'ha0fafe1788542cb123a339392a6c7605,
      128'h00000000000000000000000000000000,
      128'h0f0e0d0c0b0a09080706050403020100,
      128'h5a5a5a5aa5a5a5a5ffffffff00000000,
      128'h13579bdf02468ace8badf00d12345678 };
   localparam logic [127:0] KNOWN_OUT = 128'ha49c7ff2689f352b6b5bea43026a5049;

   function automatic logic [255:0] enc(input logic [127:0] v);
      logic [255:0] d;
      for (int i = 0; i < 128; i++) d[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
      return d;
   endfunction

   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] rol8(input logic [7:0] b, input int n);
      return (b << n) | (b >> (8 - n));
   endfunction

   function automatic logic [7:0] m_sub(input logic [7:0] x);
      logic [7:0] inv;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
      return inv ^ rol8(inv, 1) ^ rol8(inv, 2) ^ rol8(inv, 3) ^ rol8(inv, 4) ^ 8'h63;
   endfunction

   function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k);
      logic [7:0] u [16];
      logic [7:0] t [16];
      logic [127:0] o;
      for (int n = 0; n < 16; n++) u[n] = m_sub(s[127-8*n -: 8]);
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) t[4*c+r] = u[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            o[127-8*(4*c+r) -: 8] = m_mul(8'h02, t[4*c+r]) ^ m_mul(8'h03, t[4*c+(r+1)%4])
                                    ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
      return o ^ k;
   endfunction

   function automatic bit any_illegal(input logic [255:0] v);
      for (int i = 0; i < 128; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk_res(input string req, input logic [255:0] exp);
      checks++;
      if (result_dr !== exp || any_illegal(result_dr)) begin
         errors++;
         $display("FAIL %s result: actual %h expected %h", req, result_dr, exp);
      end
   endtask

   task automatic chk_ko(input string req, input logic exp);
      checks++;
      if (ko !== exp) begin
         errors++;
         $display("FAIL %s ko: actual %b expected %b", req, ko, exp);
      end
   endtask

   task automatic send_null;
      @(negedge clk);
      state_dr = '0;
      key_dr   = '0;
      ki       = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_res("R2", '0);
      chk_ko("R2", 1'b1);
      rst_n = 1'b1;

      // vector table: DATA wavefront then NULL wavefront (R1, R3, R4, R7, R8, R9)
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         state_dr = enc(VEC_S[v]);
         key_dr   = enc(VEC_K[v]);
         ki       = 1'b1;
         @(negedge clk);
         chk_res("R3", enc(m_round(VEC_S[v], VEC_K[v])));
         chk_ko("R8", 1'b0);
         send_null();
         chk_res("R7", '0);
         chk_ko("R8", 1'b1);
      end

      // known round result (R3)
      checks++;
      if (m_round(VEC_S[0], VEC_K[0]) !== KNOWN_OUT) begin
         errors++;
         $display("FAIL R3 model: actual %h expected %h", m_round(VEC_S[0], VEC_K[0]), KNOWN_OUT);
      end
      @(negedge clk);
      state_dr = enc(VEC_S[0]);
      key_dr   = enc(VEC_K[0]);
      ki       = 1'b1;
      @(negedge clk);
      chk_res("R3", enc(KNOWN_OUT));
      send_null();

      // one state pair NULL: output stays NULL (R5)
      @(negedge clk);
      state_dr = enc(VEC_S[3]);
      state_dr[2*77 +: 2] = 2'b00;
      key_dr   = enc(VEC_K[3]);
      ki       = 1'b1;
      repeat (3) @(negedge clk);
      chk_res("R5", '0);
      chk_ko("R5", 1'b1);
      // key NULL, state complete (R5)
      state_dr = enc(VEC_S[3]);
      key_dr   = '0;
      repeat (3) @(negedge clk);
      chk_res("R5", '0);
      chk_ko("R5", 1'b1);
      // completing the key releases DATA on the next edge (R4)
      key_dr = enc(VEC_K[3]);
      @(negedge clk);
      chk_res("R4", enc(m_round(VEC_S[3], VEC_K[3])));
      chk_ko("R4", 1'b0);

      // inputs NULL but ki still 1: hold (R7)
      state_dr = '0;
      key_dr   = '0;
      repeat (2) @(negedge clk);
      chk_res("R7", enc(m_round(VEC_S[3], VEC_K[3])));
      chk_ko("R7", 1'b0);
      // ki 0 but key still DATA: hold (R7)
      key_dr = enc(VEC_K[3]);
      ki     = 1'b0;
      repeat (2) @(negedge clk);
      chk_res("R7", enc(m_round(VEC_S[3], VEC_K[3])));
      // both NULL with ki 0: NULL after one edge (R7)
      key_dr = '0;
      @(negedge clk);
      chk_res("R7", '0);
      chk_ko("R7", 1'b1);

      // complete DATA with ki 0: blocked (R6)
      state_dr = enc(VEC_S[4]);
      key_dr   = enc(VEC_K[4]);
      repeat (3) @(negedge clk);
      chk_res("R6", '0);
      chk_ko("R6", 1'b1);
      ki = 1'b1;
      @(negedge clk);
      chk_res("R6", enc(m_round(VEC_S[4], VEC_K[4])));
      send_null();
      chk_res("R8", '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule